// File: doc/BRIEF.md
# ADC Conversion Control and Status Register

This block is the control side of a successive-approximation analog-to-digital converter. A host writes one byte-wide register that holds the enable, start, free-running, interrupt-enable and clock-divider settings. It reads the same register back to see whether a conversion is running and whether a result is waiting. The converter itself sits outside the block. The block gives it a divided ADC clock, a one-cycle start pulse and a marker for an extended first conversion, and it takes back a done strobe when the result has been stored.

The first conversion after enabling is the extended one, 25 ADC clocks instead of 13. The start bit stays high through that conversion until it completes. In free-running mode, each done strobe starts the next conversion at once. A completion flag records each finished conversion. The flag is cleared either by the interrupt controller's acknowledge or by the host writing a one to the flag bit. The interrupt request combines the flag, the local enable and a global enable input.

Register layout, which host software decodes: bit 7 enable, bit 6 start/busy, bit 5 free-running, bit 4 completion flag, bit 3 interrupt enable, bits 2:0 divider code.

Top module: `adc_seq_csr`

## Requirements
- R1: After reset every register bit reads 0, and `conv_start`, `conv_long`, `adc_clk` and `irq` are low.
- R2: Writing 1 to bit 6 while bit 7 (enable) is 1 in the same write makes bit 6 read 1 and pulses `conv_start` for exactly one cycle after the write. Bit 6 stays 1 until a done strobe.
- R3: Writing 0 to bit 6 has no effect. An idle block stays idle and a running conversion keeps bit 6 at 1.
- R4: The first conversion after enable is extended. `conv_long` is 1 for its whole duration and bit 6 stays 1 until its done strobe. Later conversions have `conv_long` at 0.
- R5: A done strobe during a conversion sets bit 4 (flag). Outside free-running mode it also clears bit 6.
- R6: With bit 5 (free-running) set, each done strobe issues a new `conv_start` pulse in the next cycle and bit 6 stays 1. Clearing bit 5 makes the next done strobe end the sequence.
- R7: Writing 1 to bit 4 clears the flag and writing 0 leaves it unchanged. When a done strobe arrives in the same cycle as the clearing write, the flag is left set.
- R8: `irq_ack` clears the flag.
- R9: `irq` is 1 exactly when the flag, bit 3 (interrupt enable) and `gie` are all 1.
- R10: The divider code in bits 2:0, with values 0 through 7, gives an `adc_clk` period of 2, 2, 4, 8, 16, 32, 64 and 128 system clock cycles.
- R11: Clearing bit 7 aborts a running conversion (bit 6 reads 0) and holds `adc_clk` low. Done strobes and start writes are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| conv_done | input | 1 | Conversion complete strobe from the converter |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_long | output | 1 | Current conversion is the extended first one |
| adc_clk | output | 1 | Divided ADC clock |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a flag-clearing write that lands in the same cycle as a done strobe. The bench reaches it by driving `wr_en` and `conv_done` on the same falling edge while a conversion is running. A second hard case is telling the extended first conversion apart from the later ones. For that, the bench runs two conversions back to back after a single enable and compares `conv_long` between them. For the divider, the bench measures the distance between rising edges of `adc_clk` for every code, after a fresh enable each time.

// File: rtl/adc_seq_csr.sv
module adc_seq_csr #(
  parameter int PS_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       gie,
  input  logic       irq_ack,
  input  logic       conv_done,
  output logic       conv_start,
  output logic       conv_long,
  output logic       adc_clk,
  output logic       irq
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic            en_q, busy_q, fr_q, flag_q, ie_q, used_q, long_q, start_q;
  logic [PS_W-1:0] ps_q;
  logic [DIV_W-1:0] div_q;

  logic en_nxt, fr_nxt, start_req, done_hit, flag_clr;
  logic [PS_W-1:0] tap;

  assign en_nxt    = wr_en ? wr_data[7] : en_q;
  assign fr_nxt    = wr_en ? wr_data[5] : fr_q;
  assign start_req = wr_en & wr_data[6] & en_nxt & ~busy_q;
  assign done_hit  = conv_done & busy_q & en_nxt;
  assign flag_clr  = (wr_en & wr_data[4]) | irq_ack;
  assign tap       = (ps_q == '0) ? '0 : ps_q - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; busy_q <= 1'b0; fr_q <= 1'b0; flag_q <= 1'b0;
      ie_q <= 1'b0; used_q <= 1'b0; long_q <= 1'b0; start_q <= 1'b0;
      ps_q <= '0; div_q <= '0;
    end else begin
      en_q <= en_nxt;
      fr_q <= fr_nxt;
      if (wr_en) begin
        ie_q <= wr_data[3];
        ps_q <= wr_data[PS_W-1:0];
      end
      div_q   <= en_nxt ? div_q + 1'b1 : '0;
      start_q <= start_req | (done_hit & fr_nxt);
      used_q  <= en_nxt & (used_q | start_req);

      if (!en_nxt)                 busy_q <= 1'b0;
      else if (start_req)          busy_q <= 1'b1;
      else if (done_hit && !fr_nxt) busy_q <= 1'b0;

      if (!en_nxt)        long_q <= 1'b0;
      else if (start_req) long_q <= ~used_q;
      else if (done_hit)  long_q <= 1'b0;

      if (done_hit)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign rd_data    = {en_q, busy_q, fr_q, flag_q, ie_q, ps_q};
  assign conv_start = start_q;
  assign conv_long  = long_q;
  assign adc_clk    = div_q[tap];
  assign irq        = flag_q & ie_q & gie;

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy_q);
  assert_zero_write_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[6] && !busy_q) |=> !busy_q);
  assert_done_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && busy_q && !(wr_en && !wr_data[7])) |=> flag_q);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !conv_done) |=> !flag_q);
  assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!busy_q && !adc_clk && !conv_long));
endmodule

// File: tb/adc_seq_csr_bench.sv
module adc_seq_csr_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, gie = 1'b0, irq_ack = 1'b0, conv_done = 1'b0;
  logic [7:0] wr_data = 8'h00, rd_data;
  logic conv_start, conv_long, adc_clk, irq;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  adc_seq_csr u_adc_seq_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .gie(gie), .irq_ack(irq_ack), .conv_done(conv_done), .conv_start(conv_start),
    .conv_long(conv_long), .adc_clk(adc_clk), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; conv_done = 1'b0; irq_ack = 1'b0; gie = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic done_pulse();
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 outputs", {conv_start, conv_long, adc_clk, irq}, 4'b0000);
  endtask

  task automatic t_single();
    do_reset();
    wr(8'h80);
    chk("R1 enable readback", rd_data, 8'h80);
    wr(8'hC0);
    chk("R2 start pulse", conv_start, 1'b1);
    chk("R2 busy bit", rd_data[6], 1'b1);
    chk("R4 first long", conv_long, 1'b1);
    @(negedge clk);
    chk("R2 pulse one cycle", conv_start, 1'b0);
    repeat (5) @(negedge clk);
    chk("R4 busy through long", {rd_data[6], conv_long}, 2'b11);
    wr(8'h80);
    chk("R3 zero write while busy", rd_data[6], 1'b1);
    done_pulse();
    chk("R5 flag set busy clear", rd_data, 8'h90);
    wr(8'h80);
    chk("R3 zero write idle", rd_data[6], 1'b0);
    wr(8'hC0);
    chk("R4 second not long", conv_long, 1'b0);
    chk("R2 second start", conv_start, 1'b1);
    done_pulse();
    wr(8'h80);
    chk("R7 write zero keeps flag", rd_data[4], 1'b1);
    wr(8'h90);
    chk("R7 write one clears", rd_data[4], 1'b0);
  endtask

  task automatic t_set_wins();
    do_reset();
    wr(8'h80); wr(8'hC0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h90; conv_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; conv_done = 1'b0;
    chk("R7 set beats clear", rd_data[4], 1'b1);
  endtask

  task automatic t_ack_irq();
    do_reset();
    wr(8'h88); wr(8'hC8);
    done_pulse();
    chk("R9 irq gie low", irq, 1'b0);
    gie = 1'b1; #1;
    chk("R9 irq all set", irq, 1'b1);
    wr(8'h80); #1;
    chk("R9 irq ie low", irq, 1'b0);
    wr(8'h88);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R8 ack clears flag", rd_data[4], 1'b0);
    chk("R9 irq after ack", irq, 1'b0);
  endtask

  task automatic t_freerun();
    do_reset();
    wr(8'hA0); wr(8'hE0);
    @(negedge clk);
    done_pulse();
    chk("R6 restart pulse", conv_start, 1'b1);
    chk("R6 busy kept", rd_data[6], 1'b1);
    chk("R6 flag set", rd_data[4], 1'b1);
    chk("R4 restart not long", conv_long, 1'b0);
    @(negedge clk);
    wr(8'h80);
    done_pulse();
    chk("R6 stop after clear", {conv_start, rd_data[6]}, 2'b00);
  endtask

  task automatic t_abort();
    do_reset();
    wr(8'h80); wr(8'hC0);
    wr(8'h00);
    chk("R11 abort busy", rd_data[6], 1'b0);
    chk("R11 adc_clk low", adc_clk, 1'b0);
    done_pulse();
    chk("R11 done ignored", rd_data[4], 1'b0);
    wr(8'h40);
    chk("R11 start ignored", {rd_data[6], conv_start}, 2'b00);
  endtask

  task automatic t_prescale();
    for (int code = 0; code < 8; code++) begin
      int period, exp_p;
      logic prev;
      do_reset();
      wr({5'b10000, 3'(code)});
      exp_p = (code == 0) ? 2 : (1 << code);
      prev = adc_clk;
      while (!(prev == 1'b0 && adc_clk == 1'b1)) begin
        prev = adc_clk;
        @(negedge clk);
      end
      period = 0;
      prev = adc_clk;
      do begin
        @(negedge clk);
        period++;
        if (prev == 1'b0 && adc_clk == 1'b1) break;
        prev = adc_clk;
      end while (period < 300);
      chk($sformatf("R10 period code %0d", code), period, exp_p);
    end
  endtask

  initial begin
    t_reset();
    t_single();
    t_set_wins();
    t_ack_irq();
    t_freerun();
    t_abort();
    t_prescale();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule